// File: doc/BRIEF.md
# Bidirectional Shift and Rotate Unit

This block moves an 8-bit byte left or right by zero to three bit positions in one purely combinational pass. Two single-bit controls and a 2-bit amount make up its control word. The first control picks the direction. The second picks whether bits pushed past one end are lost, with zeros filling the vacated places, or fed back in at the opposite end.

It is intended as a small datapath element next to an ALU or a bit-manipulation path. There is no register stage, so the result follows the inputs within the same cycle. The movement is built as a chain of power-of-two stages, and each bit of the amount enables one stage.

Top module: `shrot_unit`

## Requirements
- R1: With `dir_left`=1 and `rotate`=0, `dout` equals `din` moved toward the MSB by `amt` places, and the low `amt` bits are 0.
- R2: With `dir_left`=0 and `rotate`=0, `dout` equals `din` moved toward the LSB by `amt` places, and the high `amt` bits are 0.
- R3: With `dir_left`=1 and `rotate`=1, each bit i of `din` appears at bit (i+`amt`) mod 8 of `dout`.
- R4: With `dir_left`=0 and `rotate`=1, each bit i of `din` appears at bit (i-`amt`) mod 8 of `dout`.
- R5: When `amt`=0, `dout` equals `din` for every setting of `dir_left` and `rotate`.
- R6: `dout` is combinational. It reflects a change on any input with no clock edge in between.
- R7: In rotate mode, `dout` holds the same number of 1 bits as `din`.
- R8: At the largest amount (`amt`=3), shifting 8'hFF gives 8'hF8 to the left and 8'h1F to the right. Rotating 8'h01 gives 8'h08 to the left and 8'h20 to the right.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 8 | Byte to be moved |
| dir_left | input | 1 | 1 moves toward the MSB, 0 moves toward the LSB |
| rotate | input | 1 | 1 wraps bits round, 0 drops them and fills with zeros |
| amt | input | 2 | Number of bit positions, 0 to 3 |
| dout | output | 8 | Moved byte |

## Verification
The bench goes after the wrap boundary, where a rotate that dropped its carried-out bits would lose ones. It also covers the fill side of a shift, where a fill of ones or a wrap instead of zeros would show up in the vacated bits. Every combination of data, direction, mode and amount is applied. A stage wired to the wrong power of two, or a swapped direction, therefore gives a wrong byte at amounts 1, 2 or 3. A zero amount that still moved data would break the pass-through cases.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic {DIR_RIGHT = 1'b0, DIR_LEFT = 1'b1} dir_e;
  typedef enum logic {MODE_SHIFT = 1'b0, MODE_ROTATE = 1'b1} mode_e;
endpackage

// File: rtl/shrot_ctrl.sv
module shrot_ctrl (
  input  logic                  dir_bit,
  input  logic                  mode_bit,
  output shrot_pkg::dir_e       dir,
  output shrot_pkg::mode_e      mode
);
  assign dir  = shrot_pkg::dir_e'(dir_bit);
  assign mode = shrot_pkg::mode_e'(mode_bit);
endmodule

// File: rtl/shrot_stage.sv
module shrot_stage #(
  parameter int W    = 8,
  parameter int STEP = 1
) (
  input  logic             en,
  input  shrot_pkg::dir_e  dir,
  input  shrot_pkg::mode_e mode,
  input  logic [W-1:0]     in_v,
  output logic [W-1:0]     out_v
);
  import shrot_pkg::*;
  localparam logic [STEP-1:0] FILL0 = '0;

  always_comb begin
    if (!en) begin
      out_v = in_v;
    end else if (dir == DIR_LEFT) begin
      if (mode == MODE_ROTATE) out_v = {in_v[W-STEP-1:0], in_v[W-1:W-STEP]};
      else                     out_v = {in_v[W-STEP-1:0], FILL0};
    end else begin
      if (mode == MODE_ROTATE) out_v = {in_v[STEP-1:0], in_v[W-1:STEP]};
      else                     out_v = {FILL0, in_v[W-1:STEP]};
    end
  end

  always_comb begin
    // R7
    if (mode == MODE_ROTATE)
      stage_ones_kept_chk: assert ($countones(out_v) == $countones(in_v));
    // R1
    if (mode == MODE_SHIFT)
      stage_no_new_ones_chk: assert ($countones(out_v) <= $countones(in_v));
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit #(
  parameter int W     = 8,
  parameter int AMT_W = 2
) (
  input  logic [W-1:0]     din,
  input  logic             dir_left,
  input  logic             rotate,
  input  logic [AMT_W-1:0] amt,
  output logic [W-1:0]     dout
);
  import shrot_pkg::*;
  localparam int NSTAGE = AMT_W;

  dir_e  dir;
  mode_e mode;
  logic [W-1:0] lane [NSTAGE+1];

  shrot_ctrl u_ctrl (
    .dir_bit  (dir_left),
    .mode_bit (rotate),
    .dir      (dir),
    .mode     (mode)
  );

  assign lane[0] = din;

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    shrot_stage #(.W(W), .STEP(1 << i)) u_stage (
      .en    (amt[i]),
      .dir   (dir),
      .mode  (mode),
      .in_v  (lane[i]),
      .out_v (lane[i+1])
    );
  end

  assign dout = lane[NSTAGE];

  always_comb begin
    // R5
    if (amt == '0)
      zero_amt_pass_chk: assert (dout == din);
    // R7
    if (rotate)
      rot_ones_kept_chk: assert ($countones(dout) == $countones(din));
    // R1
    if (!rotate && dir_left && amt != '0)
      left_fill_zero_chk: assert (dout[0] == 1'b0);
    // R2
    if (!rotate && !dir_left && amt != '0)
      right_fill_zero_chk: assert (dout[W-1] == 1'b0);
  end
endmodule

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = '0;
  logic       dir_left = 1'b0;
  logic       rotate = 1'b0;
  logic [1:0] amt = '0;
  logic [7:0] dout;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shrot_unit u_dut (
    .din(din), .dir_left(dir_left), .rotate(rotate), .amt(amt), .dout(dout)
  );

  function automatic logic [7:0] model(input logic [7:0] d, input logic l,
                                       input logic r, input logic [1:0] a);
    logic [7:0] v = d;
    for (int k = 0; k < int'(a); k++) begin
      if (l) v = {v[6:0], r ? v[7] : 1'b0};
      else   v = {r ? v[0] : 1'b0, v[7:1]};
    end
    return v;
  endfunction

  function automatic string req_of(input logic l, input logic r, input logic [1:0] a);
    if (a == 2'd0) return "R5";
    if (!r) return l ? "R1" : "R2";
    return l ? "R3" : "R4";
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    n_vec++;
    if (dout !== exp) begin
      n_bad++;
      $display("FAIL %s din=%h left=%b rot=%b amt=%0d got=%h exp=%h",
               req, din, dir_left, rotate, amt, dout, exp);
    end
  endtask

  task automatic apply(input logic [7:0] d, input logic l, input logic r,
                       input logic [1:0] a, input string req);
    @(negedge clk);
    din = d; dir_left = l; rotate = r; amt = a;
    #1;
    check(req, model(d, l, r, a));
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero inputs give zero output (R5)
    @(negedge clk); #1; check("R5", 8'h00);
    // R8 directed boundaries
    apply(8'hFF, 1'b1, 1'b0, 2'd3, "R8");
    apply(8'hFF, 1'b0, 1'b0, 2'd3, "R8");
    apply(8'h01, 1'b1, 1'b1, 2'd3, "R8");
    apply(8'h01, 1'b0, 1'b1, 2'd3, "R8");
    // R6: change inputs mid-cycle, result follows without a clock edge
    @(posedge clk); #1;
    din = 8'h81; dir_left = 1'b1; rotate = 1'b1; amt = 2'd1; #1;
    check("R6", 8'h03);
    amt = 2'd2; #1;
    check("R6", 8'h06);
    // exhaustive sweep R1 R2 R3 R4 R5
    for (int d = 0; d < 256; d++)
      for (int c = 0; c < 16; c++)
        apply(8'(d), c[3], c[2], c[1:0], req_of(c[3], c[2], c[1:0]));
    // random mix, with R7 ones count check on rotates
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv = $urandom;
      apply(rv[7:0], rv[8], rv[9], rv[11:10], req_of(rv[8], rv[9], rv[11:10]));
      if (rv[9]) begin
        n_vec++;
        if ($countones(dout) != $countones(rv[7:0])) begin
          n_bad++;
          $display("FAIL R7 ones got=%0d exp=%0d", $countones(dout), $countones(rv[7:0]));
        end
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog got=timeout exp=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule